// File: doc/BRIEF.md
# Asynchronous Serial Receiver

This block receives character frames on a single serial input line that idles high. It watches the line on an oversampling tick. A falling edge is a candidate start bit, and that start bit is confirmed at its centre. The block then samples each following bit at its centre and assembles the data bits least significant first. When parity is enabled it checks the parity bit, and it checks every configured stop bit. At the end of the frame the character is copied into a readable data register and a full flag is raised. An optional interrupt line follows that flag.

Software configures the block and reads results through a small register port. The port has a 2-bit address, separate read and write strobes, and a registered read-data bus. Configuration covers the enable, the interrupt enable, 7- or 8-bit characters, parity on or off, odd or even parity, and one or two stop bits. The status register reports four sticky flags: full, framing error, parity error and overrun. A status flag is cleared only by a two-step sequence. Software first reads the status register while the flag is set, then writes 0 to that flag's bit.

Top module: `serial_rx_unit`

## Requirements
- R1: While the enable (control bit 0, address 0) is 0, the line is ignored and no frame completes. Clearing the enable in the middle of a frame abandons that frame, and no status flag changes.
- R2: In idle, a low line seen on a tick starts a candidate start bit. It is re-sampled OSR/2 ticks later. If the line is high at that point, the candidate is dropped and nothing is received.
- R3: Data bits arrive least significant bit first. Each bit is sampled OSR ticks after the previous sample. The completed character reads back from the data register at address 2.
- R4: Control bit 5 selects two stop bits (1) or one stop bit (0). If any configured stop bit is sampled as 0, status bit 1 (framing error) is set. The character is still delivered and the full flag is still set.
- R5: When control bit 2 is 1, characters are 7 bits long and bit 7 of the data register reads 0.
- R6: Control bit 3 enables a parity bit after the data bits. Control bit 4 selects odd parity (1) or even parity (0). A mismatch sets status bit 2 (parity error).
- R7: A completed frame sets status bit 0 (full) at address 1. irq_o is 1 whenever the full flag is 1 and control bit 1 (interrupt enable) is 1.
- R8: A status flag clears only when software writes 0 to it at address 1 after a status read that returned it as 1. A write without such a read leaves the flag set. Writing 1 has no effect. Any status write ends the read-arming.
- R9: A frame that completes while the full flag is 1 sets status bit 3 (overrun). In that case the data register and the framing and parity flags are left unchanged.
- R10: After reset every register reads 0 and irq_o is 0. Read data appears on reg_rdata_o in the cycle after the read strobe and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling tick, OSR ticks per bit |
| rx_i | input | 1 | Serial line, idles high |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with its defaults, OSR 16 and DW 8, and drives a tick on every second clock, so one bit lasts 32 clocks. At that rate a 12-bit frame finishes in about 400 cycles. That lets the run cover every framing mode: 7 and 8 data bits, no parity, even and odd parity, and one or two stop bits with either stop bit corrupted. It also leaves room for glitch rejection, a frame abandoned mid-way and overrun on back-to-back frames. Because OSR is 16, the half-bit confirmation point falls 8 ticks after the falling edge, so a 2-tick glitch is clearly rejected.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SW = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int C_EN    = 0;
  localparam int C_IRQ   = 1;
  localparam int C_LEN7  = 2;
  localparam int C_PAR   = 3;
  localparam int C_ODD   = 4;
  localparam int C_STOP2 = 5;

  localparam int S_FULL = 0;
  localparam int S_FRM  = 1;
  localparam int S_PAR  = 2;
  localparam int S_OVR  = 3;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '1;
    else       chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          len7_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          stop2_i,
  output logic          done_o,
  output logic [DW-1:0] char_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          busy_o
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int IW   = $clog2(DW + 4);
  localparam int XW   = $clog2(DW);

  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] sr_q;
  logic          par_q;
  logic          ferr_q;

  logic [IW-1:0] dlen, last_idx;
  logic          is_data, is_par, half_hit, bit_hit;

  always_comb begin
    dlen     = len7_i ? IW'(DW - 1) : IW'(DW);
    last_idx = dlen + IW'(par_en_i) + IW'(stop2_i);
    is_data  = idx_q < dlen;
    is_par   = par_en_i && (idx_q == dlen);
    half_hit = cnt_q == CW'(HALF - 1);
    bit_hit  = cnt_q == CW'(OSR - 1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sr_q   <= '0;
      par_q  <= 1'b0;
      ferr_q <= 1'b0;
      done_o <= 1'b0;
      char_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        case (st_q)
          RX_IDLE: begin
            if (!rxd_i) begin
              st_q  <= RX_START;
              cnt_q <= '0;
            end
          end
          RX_START: begin
            if (half_hit) begin
              cnt_q <= '0;
              if (rxd_i) begin
                st_q <= RX_IDLE;
              end else begin
                st_q   <= RX_BITS;
                idx_q  <= '0;
                sr_q   <= '0;
                par_q  <= 1'b0;
                ferr_q <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_BITS: begin
            if (bit_hit) begin
              cnt_q <= '0;
              if (is_data) begin
                sr_q[idx_q[XW-1:0]] <= rxd_i;
                par_q <= par_q ^ rxd_i;
              end else if (is_par) begin
                par_q <= par_q ^ rxd_i;
              end else if (!rxd_i) begin
                ferr_q <= 1'b1;
              end
              if (idx_q == last_idx) begin
                st_q   <= RX_IDLE;
                done_o <= 1'b1;
                char_o <= len7_i ? {1'b0, sr_q[DW-2:0]} : sr_q;
                perr_o <= par_en_i & (par_q ^ par_odd_i);
                ferr_o <= ferr_q | ~rxd_i;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy_o = st_q != RX_IDLE;
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  input  logic [DW-1:0] char_i,
  input  logic          perr_i,
  input  logic          ferr_i,
  output logic [DW-1:0] ctrl_o,
  output logic [SW-1:0] stat_o,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [DW-1:0] ctrl_q, ctrl_n, data_q;
  logic [SW-1:0] stat_q, stat_n, armed_q, clr, kept;
  logic          wr_stat, rd_stat, take;

  always_comb begin
    wr_stat = wr_i && (addr_i == A_STAT);
    rd_stat = rd_i && (addr_i == A_STAT);
    clr     = wr_stat ? (armed_q & ~wdata_i[SW-1:0]) : '0;
    kept    = stat_q & ~clr;
    take    = done_i && !kept[S_FULL];
    stat_n  = kept;
    if (done_i) begin
      if (kept[S_FULL]) begin
        stat_n[S_OVR] = 1'b1;
      end else begin
        stat_n[S_FULL] = 1'b1;
        stat_n[S_FRM]  = kept[S_FRM] | ferr_i;
        stat_n[S_PAR]  = kept[S_PAR] | perr_i;
      end
    end
    ctrl_n = (wr_i && (addr_i == A_CTRL)) ? wdata_i : ctrl_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      armed_q <= '0;
      data_q  <= '0;
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      stat_q <= stat_n;
      irq_o  <= stat_n[S_FULL] & ctrl_n[C_IRQ];
      if (take) data_q <= char_i;
      if (rd_stat)      armed_q <= stat_q;
      else if (wr_stat) armed_q <= '0;
      if (rd_i) begin
        case (addr_i)
          A_CTRL:  rdata_o <= ctrl_q;
          A_STAT:  rdata_o <= {{(DW-SW){1'b0}}, stat_q};
          A_DATA:  rdata_o <= data_q;
          default: rdata_o <= '0;
        endcase
      end else begin
        rdata_o <= '0;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
  assign data_o = data_q;
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import srx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic          rx_s;
  logic [DW-1:0] cfg_w, data_w, char_w;
  logic [SW-1:0] stat_w;
  logic          frame_done, perr_w, ferr_w, rx_busy;
  logic          en_w, irq_en_w, len7_w;

  assign en_w     = cfg_w[C_EN];
  assign irq_en_w = cfg_w[C_IRQ];
  assign len7_w   = cfg_w[C_LEN7];

  srx_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  srx_framer #(.OSR(OSR), .DW(DW)) u_framer (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_w),
    .tick_i    (tick_i),
    .rxd_i     (rx_s),
    .len7_i    (len7_w),
    .par_en_i  (cfg_w[C_PAR]),
    .par_odd_i (cfg_w[C_ODD]),
    .stop2_i   (cfg_w[C_STOP2]),
    .done_o    (frame_done),
    .char_o    (char_w),
    .perr_o    (perr_w),
    .ferr_o    (ferr_w),
    .busy_o    (rx_busy)
  );

  srx_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .wdata_i (reg_wdata_i),
    .done_i  (frame_done),
    .char_i  (char_w),
    .perr_i  (perr_w),
    .ferr_i  (ferr_w),
    .ctrl_o  (cfg_w),
    .stat_o  (stat_w),
    .data_o  (data_w),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          irq_en,
  input logic          len7,
  input logic          busy,
  input logic          done,
  input logic [3:0]    stat,
  input logic [DW-1:0] data,
  input logic          wr,
  input logic [1:0]    addr,
  input logic          wbit0,
  input logic          irq
);
  AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy); // R1

  AST_SHORT_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && len7 && !stat[0]) |=> !data[DW-1]); // R5

  AST_FULL_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($rose(stat[0]) && irq_en) |-> irq); // R7

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat[0] && !(wr && addr == 2'd1)) |=> stat[0]); // R8

  AST_FULL_CLEARS_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(stat[0]) |-> $past(wr && addr == 2'd1 && !wbit0)); // R8

  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[3]) |-> $stable(data)); // R9
endmodule

bind serial_rx_unit srx_checker #(.DW(DW)) u_srx_chk (
  .clk    (clk_i),
  .rst    (rst_i),
  .en     (en_w),
  .irq_en (irq_en_w),
  .len7   (len7_w),
  .busy   (rx_busy),
  .done   (frame_done),
  .stat   (stat_w),
  .data   (data_w),
  .wr     (reg_wr_i),
  .addr   (reg_addr_i),
  .wbit0  (reg_wdata_i[0]),
  .irq    (irq_o)
);

// File: tb/serial_rx_unit_bench.sv
module serial_rx_unit_bench;
  localparam int OSR = 16;
  localparam int DW  = 8;
  localparam int BIT = OSR * 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick;
  logic          rx = 1'b1;
  logic [1:0]    addr = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;

  typedef struct packed { logic [3:0] st; logic [7:0] d; } exp_t;
  exp_t sb_q[$];

  logic [3:0] m_stat = '0;
  logic [7:0] m_data = '0;
  logic [7:0] m_ctrl = '0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= ~tick;
  end

  serial_rx_unit #(.OSR(OSR), .DW(DW)) u_serial_rx_unit (
    .clk_i       (clk),
    .rst_i       (rst),
    .tick_i      (tick),
    .rx_i        (rx),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    v = rdata;
    rd = 1'b0;
  endtask

  task automatic set_ctrl(input logic [7:0] c);
    m_ctrl = c;
    reg_write(2'd0, c);
  endtask

  task automatic line(input logic v);
    rx = v;
    repeat (BIT) @(negedge clk);
  endtask

  // driver: sends one frame and pushes the expected status/data
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic [1:0] bad_stop);
    int n;
    logic p;
    exp_t e;
    n = m_ctrl[2] ? 7 : 8;
    p = m_ctrl[4];
    for (int i = 0; i < n; i++) p = p ^ d[i];
    if (bad_par) p = ~p;
    line(1'b0);
    for (int i = 0; i < n; i++) line(d[i]);
    if (m_ctrl[3]) line(p);
    line(~bad_stop[0]);
    if (m_ctrl[5]) line(~bad_stop[1]);
    line(1'b1);
    if (m_ctrl[0]) begin
      if (m_stat[0]) begin
        m_stat[3] = 1'b1;
      end else begin
        m_stat[0] = 1'b1;
        m_stat[1] = m_stat[1] | bad_stop[0] | (m_ctrl[5] & bad_stop[1]);
        m_stat[2] = m_stat[2] | (m_ctrl[3] & bad_par);
        m_data    = m_ctrl[2] ? {1'b0, d[6:0]} : d;
      end
    end
    e.st = m_stat; e.d = m_data;
    sb_q.push_back(e);
  endtask

  // monitor: pops the expectation and compares against the design
  task automatic check_frame(input string tag);
    exp_t e;
    logic [7:0] v;
    e = sb_q.pop_front();
    reg_read(2'd1, v);
    check({tag, " status"}, v, {4'h0, e.st});
    reg_read(2'd2, v);
    check({tag, " data"}, v, e.d);
    check({tag, " irq"}, irq, e.st[0] & m_ctrl[1]);
  endtask

  task automatic clear_all();
    logic [7:0] v;
    reg_read(2'd1, v);
    reg_write(2'd1, 8'h00);
    m_stat = '0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R10 reset state
    check("R10 irq after reset", irq, 0);
    check("R10 rdata idle", rdata, 0);
    reg_read(2'd0, v); check("R10 ctrl reset", v, 0);
    reg_read(2'd1, v); check("R10 stat reset", v, 0);
    reg_read(2'd2, v); check("R10 data reset", v, 0);

    // R1 disabled receiver ignores the line
    send_frame(8'hA5, 0, 2'b00);
    check_frame("R1 disabled");

    // R3 / R7 plain 8N1 frame, interrupt enabled
    set_ctrl(8'h03);
    send_frame(8'h5A, 0, 2'b00);
    check_frame("R3 R7 8N1");
    reg_read(2'd0, v); check("R10 ctrl readback", v, 8'h03);

    // R8 write of 1 and unarmed write of 0 leave the flag
    reg_write(2'd1, 8'hFF);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, v); check("R8 unarmed write kept", v, 8'h01);
    check("R8 irq still set", irq, 1);
    reg_write(2'd1, 8'h00);
    m_stat = '0;
    reg_read(2'd1, v); check("R8 armed write cleared", v, 8'h00);
    check("R7 irq dropped", irq, 0);

    // R9 overrun keeps old data
    send_frame(8'hC3, 0, 2'b00);
    check_frame("R3 second char");
    send_frame(8'h3C, 0, 2'b11);
    check_frame("R9 overrun");
    clear_all();

    // R5 seven-bit characters
    set_ctrl(8'h07);
    send_frame(8'hFF, 0, 2'b00);
    check_frame("R5 short char");
    clear_all();

    // R6 even and odd parity
    set_ctrl(8'h0B);
    send_frame(8'h3D, 0, 2'b00);
    check_frame("R6 even ok");
    clear_all();
    send_frame(8'h3D, 1, 2'b00);
    check_frame("R6 even bad");
    clear_all();
    set_ctrl(8'h1B);
    send_frame(8'h81, 0, 2'b00);
    check_frame("R6 odd ok");
    clear_all();
    send_frame(8'h81, 1, 2'b00);
    check_frame("R6 odd bad");
    clear_all();

    // R4 stop bit checks
    set_ctrl(8'h03);
    send_frame(8'h96, 0, 2'b01);
    check_frame("R4 bad stop");
    clear_all();
    set_ctrl(8'h23);
    send_frame(8'h69, 0, 2'b00);
    check_frame("R4 two stops ok");
    clear_all();
    send_frame(8'h69, 0, 2'b10);
    check_frame("R4 second stop bad");
    clear_all();

    // R2 short glitch is rejected
    set_ctrl(8'h03);
    rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (BIT * 12) @(negedge clk);
    reg_read(2'd1, v); check("R2 glitch ignored", v, 8'h00);

    // R1 disabling mid-frame abandons it
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (8) @(negedge clk);
    set_ctrl(8'h00);
    set_ctrl(8'h03);
    repeat (BIT * 12) @(negedge clk);
    reg_read(2'd1, v); check("R1 abort status", v, 8'h00);
    check("R1 abort irq", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule